// File: doc/BRIEF.md
# Maskable Status Interrupt Controller

This block gathers three event sources from a packet protocol engine: transmit done, receive data ready and maximum retransmits reached. It holds them as sticky flags in a status word and drives one active-low interrupt line towards a host. Each event arrives as a single-cycle pulse. The host clears flags by writing ones to the status write port. It picks which flags may pull the interrupt line low through a mask that it loads over a separate configuration write port.

Each receive event carries a 3-bit pipe number. The block remembers the pipe of the latest receive event. It copies that value into the status word only at the moment the interrupt line goes from high to low. The pipe field in the status word therefore describes the packet that was current when the interrupt fired. When no receive flag is pending, the pipe field reads as all ones.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the flags read 3'b000, the mask reads 3'b000, `irq_n_o` is 1 and the pipe field (`status_o[5:3]`) reads 3'b111.
- R2: An event pulse sets its flag on the next clock edge. The flag bit positions in `status_o[2:0]` are bit 0 for transmit done, bit 1 for receive ready and bit 2 for max retransmits.
- R3: A status write clears every flag whose `stat_wdata_i` bit is 1, and leaves every flag whose bit is 0 unchanged.
- R4: When an event and a clearing write hit the same flag in the same cycle, the flag is set after the edge.
- R5: `irq_n_o` is 0 exactly while at least one set flag has its mask bit at 0. It follows the registered flags and mask with no further delay.
- R6: A mask bit at 1 stops its flag from driving `irq_n_o`, but the flag still sets on an event.
- R7: A configuration write loads `cfg_mask_i` into the mask on the next edge. `mask_o` uses the same bit order as the flags.
- R8: The pipe field is loaded only on an edge where `irq_n_o` goes from 1 to 0. It loads the pipe of a receive event in that same cycle if there is one, and otherwise the pipe of the most recent earlier receive event (3'b111 if there has been none).
- R9: While the receive flag is clear, the pipe field reads 3'b111 whatever value was captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_done_i | input | 1 | Transmit-done event pulse |
| rx_ready_i | input | 1 | Receive-ready event pulse |
| max_retry_i | input | 1 | Max-retransmit event pulse |
| rx_pipe_i | input | 3 | Pipe number, valid with `rx_ready_i` |
| stat_wr_i | input | 1 | Status write strobe (write one to clear) |
| stat_wdata_i | input | 3 | Clear pattern for the flags |
| cfg_wr_i | input | 1 | Mask write strobe |
| cfg_mask_i | input | 3 | New mask value |
| status_o | output | 6 | {pipe field, flags} |
| mask_o | output | 3 | Current mask |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
Every flag, mask and pipe-field change lands on the first clock edge after the stimulus. `irq_n_o` is decoded without a register from that registered state, so it changes at the same edge. The bench drives each stimulus at a falling edge and holds it through one rising edge. It compares all outputs shortly after that rising edge and removes the stimulus before the next one, so every expected value is due exactly one edge after its vector. Each table row also carries the state that earlier rows leave behind, so ordering effects are checked as well. Among them are the held receive pipe and a mask release that fires the interrupt.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    localparam int SRC_N    = 3;
    localparam int PIPE_W   = 3;
    localparam int IDX_TX   = 0;
    localparam int IDX_RX   = 1;
    localparam int IDX_MAXR = 2;
endpackage

// File: rtl/evt_irq_flags.sv
module evt_irq_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_en_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o,
    output logic [N-1:0] flags_nxt_o
);
    typedef struct packed {
        logic [N-1:0] flags;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (set_i[i])
                st_d.flags[i] = 1'b1;
            else if (clr_en_i && clr_i[i])
                st_d.flags[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o     = st_q.flags;
    assign flags_nxt_o = st_d.flags;

    // R2 R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));

    // R3
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && |(clr_i & ~set_i)) |=> ((flags_o & $past(clr_i & ~set_i)) == '0));

    // R3
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|set_i) && !clr_en_i) |=> $stable(flags_o));
endmodule

// File: rtl/evt_irq_pipe.sv
module evt_irq_pipe #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_ev_i,
    input  logic [W-1:0] rx_pipe_i,
    input  logic         arm_i,
    output logic [W-1:0] pipe_o
);
    localparam logic [W-1:0] NONE = '1;

    typedef struct packed {
        logic [W-1:0] last;
        logic [W-1:0] pipe;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rx_ev_i) st_d.last = rx_pipe_i;
        if (arm_i)   st_d.pipe = st_d.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{last: NONE, pipe: NONE};
        else        st_q <= st_d;
    end

    assign pipe_o = st_q.pipe;

    // R8
    pipe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> $stable(pipe_o));

    // R8
    pipe_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && rx_ev_i) |=> (pipe_o == $past(rx_pipe_i)));
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int N  = SRC_N,
    parameter int PW = PIPE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_done_i,
    input  logic          rx_ready_i,
    input  logic          max_retry_i,
    input  logic [PW-1:0] rx_pipe_i,
    input  logic          stat_wr_i,
    input  logic [N-1:0]  stat_wdata_i,
    input  logic          cfg_wr_i,
    input  logic [N-1:0]  cfg_mask_i,
    output logic [PW+N-1:0] status_o,
    output logic [N-1:0]  mask_o,
    output logic          irq_n_o
);
    typedef struct packed {
        logic [N-1:0] mask;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0]  ev;
    logic [N-1:0]  flags_q, flags_d;
    logic [PW-1:0] pipe_cap;
    logic          act_q, act_d, arm;

    always_comb begin
        ev           = '0;
        ev[IDX_TX]   = tx_done_i;
        ev[IDX_RX]   = rx_ready_i;
        ev[IDX_MAXR] = max_retry_i;
    end

    always_comb begin
        st_d = st_q;
        if (cfg_wr_i) st_d.mask = cfg_mask_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    evt_irq_flags #(.N(N)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (ev),
        .clr_en_i   (stat_wr_i),
        .clr_i      (stat_wdata_i),
        .flags_o    (flags_q),
        .flags_nxt_o(flags_d)
    );

    assign act_q = |(flags_q & ~st_q.mask);
    assign act_d = |(flags_d & ~st_d.mask);
    assign arm   = act_d && !act_q;

    evt_irq_pipe #(.W(PW)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_ev_i  (rx_ready_i),
        .rx_pipe_i(rx_pipe_i),
        .arm_i    (arm),
        .pipe_o   (pipe_cap)
    );

    assign irq_n_o  = !act_q;
    assign mask_o   = st_q.mask;
    assign status_o = {(flags_q[IDX_RX] ? pipe_cap : {PW{1'b1}}), flags_q};

    // R6
    mask_all_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_o) |-> irq_n_o);

    // R5 R7
    irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n_o) |-> ($past(|ev) || $past(cfg_wr_i)));

    // R7
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_i |=> (mask_o == $past(cfg_mask_i)));
endmodule

// File: tb/evt_irq_ctrl_bench.sv
module evt_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_done_i = 1'b0, rx_ready_i = 1'b0, max_retry_i = 1'b0;
    logic [2:0] rx_pipe_i = '0;
    logic       stat_wr_i = 1'b0;
    logic [2:0] stat_wdata_i = '0;
    logic       cfg_wr_i = 1'b0;
    logic [2:0] cfg_mask_i = '0;
    logic [5:0] status_o;
    logic [2:0] mask_o;
    logic       irq_n_o;

    int applied = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    evt_irq_ctrl u_evt_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .tx_done_i(tx_done_i), .rx_ready_i(rx_ready_i), .max_retry_i(max_retry_i),
        .rx_pipe_i(rx_pipe_i), .stat_wr_i(stat_wr_i), .stat_wdata_i(stat_wdata_i),
        .cfg_wr_i(cfg_wr_i), .cfg_mask_i(cfg_mask_i),
        .status_o(status_o), .mask_o(mask_o), .irq_n_o(irq_n_o)
    );

    // {ev(max,rx,tx), pipe, swr, sdata, cwr, cmask, exp_status, exp_mask, exp_irq_n}
    localparam int NV = 14;
    localparam logic [23:0] VEC [NV] = '{
        {3'b001, 3'd0, 1'b0, 3'b000, 1'b0, 3'b000, 6'b111001, 3'b000, 1'b0}, // R2 R5 R9
        {3'b010, 3'd3, 1'b0, 3'b000, 1'b0, 3'b000, 6'b111011, 3'b000, 1'b0}, // R8 no capture while low
        {3'b000, 3'd0, 1'b1, 3'b011, 1'b0, 3'b000, 6'b111000, 3'b000, 1'b1}, // R3
        {3'b010, 3'd6, 1'b0, 3'b000, 1'b0, 3'b000, 6'b110010, 3'b000, 1'b0}, // R8 same-cycle pipe
        {3'b000, 3'd0, 1'b1, 3'b101, 1'b0, 3'b000, 6'b110010, 3'b000, 1'b0}, // R3 zeros keep
        {3'b000, 3'd0, 1'b0, 3'b000, 1'b1, 3'b010, 6'b110010, 3'b010, 1'b1}, // R6 R7
        {3'b010, 3'd2, 1'b1, 3'b010, 1'b0, 3'b000, 6'b110010, 3'b010, 1'b1}, // R4
        {3'b000, 3'd0, 1'b0, 3'b000, 1'b1, 3'b000, 6'b010010, 3'b000, 1'b0}, // R8 held pipe
        {3'b000, 3'd0, 1'b1, 3'b010, 1'b0, 3'b000, 6'b111000, 3'b000, 1'b1}, // R3 R9
        {3'b100, 3'd0, 1'b0, 3'b000, 1'b1, 3'b111, 6'b111100, 3'b111, 1'b1}, // R6
        {3'b001, 3'd0, 1'b0, 3'b000, 1'b0, 3'b000, 6'b111101, 3'b111, 1'b1}, // R6
        {3'b000, 3'd0, 1'b0, 3'b000, 1'b1, 3'b011, 6'b111101, 3'b011, 1'b0}, // R5 R9
        {3'b010, 3'd4, 1'b1, 3'b111, 1'b0, 3'b000, 6'b010010, 3'b011, 1'b1}, // R4 R3 R8
        {3'b000, 3'd0, 1'b0, 3'b000, 1'b1, 3'b000, 6'b100010, 3'b000, 1'b0}  // R8 R7
    };

    task automatic check(string req, logic [5:0] es, logic [2:0] em, logic ei);
        applied++;
        if (status_o !== es || mask_o !== em || irq_n_o !== ei) begin
            bad++;
            $display("FAIL %s: status=%b mask=%b irq_n=%b expected status=%b mask=%b irq_n=%b",
                     req, status_o, mask_o, irq_n_o, es, em, ei);
        end
    endtask

    task automatic idle_inputs();
        {max_retry_i, rx_ready_i, tx_done_i} = 3'b000;
        rx_pipe_i = '0; stat_wr_i = 0; stat_wdata_i = '0; cfg_wr_i = 0; cfg_mask_i = '0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

    initial begin
        #1;
        check("R1 during reset", 6'b111000, 3'b000, 1'b1);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 6'b111000, 3'b000, 1'b1);

        for (int v = 0; v < NV; v++) begin
            logic [23:0] w;
            w = VEC[v];
            @(negedge clk);
            {max_retry_i, rx_ready_i, tx_done_i} = w[23:21];
            rx_pipe_i    = w[20:18];
            stat_wr_i    = w[17];
            stat_wdata_i = w[16:14];
            cfg_wr_i     = w[13];
            cfg_mask_i   = w[12:10];
            @(posedge clk);
            #1;
            check($sformatf("vector %0d R2-R9 table", v), w[9:4], w[3:1], w[0]);
            idle_inputs();
        end

        // R5 R8: idle cycles leave everything in place
        repeat (3) @(posedge clk);
        #1;
        check("R5 idle hold", 6'b100010, 3'b000, 1'b0);

        // R2: max retransmit event while unmasked
        @(negedge clk); max_retry_i = 1'b1;
        @(posedge clk); #1;
        check("R2 max retry flag", 6'b100110, 3'b000, 1'b0);
        idle_inputs();

        // R1: reset in mid-operation
        @(negedge clk); rst_n = 1'b0;
        #1;
        check("R1 mid-run reset", 6'b111000, 3'b000, 1'b1);
        @(negedge clk); rst_n = 1'b1;

        // R8: first receive after reset with no pipe history, via mask release
        @(negedge clk); cfg_wr_i = 1'b1; cfg_mask_i = 3'b010;
        @(posedge clk); #1; idle_inputs();
        @(negedge clk); rx_ready_i = 1'b1; rx_pipe_i = 3'd5;
        @(posedge clk); #1;
        check("R6 masked rx sets flag", 6'b111010, 3'b010, 1'b1);
        idle_inputs();
        @(negedge clk); cfg_wr_i = 1'b1; cfg_mask_i = 3'b000;
        @(posedge clk); #1;
        check("R8 capture on release", 6'b101010, 3'b000, 1'b0);
        idle_inputs();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end
endmodule